// File: doc/BRIEF.md
# Sample-Paced DDS Tuning Word Loader

This block keeps a direct digital synthesizer's frequency register in step with a fixed audio sample rate. An internal pacer divides the system clock down to the sample rate. On every sample instant the block drives the DDS update strobe high, which commits the word shifted in during the previous period. In the same cycle it pulses a conversion request to the ADC.

When the ADC signals that its conversion has finished, the block captures the sample and registers the 40-bit tuning word that is present on its input. It then pulls the strobe low and shifts the word out over a clock-idle-low, rising-edge-sampled serial link. The strobe stays low after the last bit. The new frequency therefore takes effect on the next sample instant rather than whenever the shift ends, so the commit time does not depend on how long the conversion and the arithmetic upstream took.

Upstream logic computes the tuning word from the previous sample and must present it on `word_in` by the time `adc_done` is raised. A sticky flag reports a sample instant that arrived before the previous frame had finished.

Top module: `dds_word_loader`

## Requirements
- R1: `adc_start` pulses for one cycle once every CLK_HZ/SAMPLE_HZ clock cycles. With the default values that is every 1250 cycles (40 kHz). SAMPLE_HZ = 20000 is also a valid setting.
- R2: In the cycle `adc_start` is high, `latch` is high. A rising edge of `latch` only occurs together with `adc_start`.
- R3: `adc_done` seen while a conversion is awaited has three effects in the following cycle: `sample_out` holds `adc_data`, `sample_valid` is high for exactly one cycle, and `latch` is low.
- R4: A frame is 40 bits sent MSB first: `word_in[39:32]` (control/phase byte) first, then frequency bits 31:24, 23:16, 15:8 and 7:0. Exactly 40 rising `sclk` edges occur per completed frame.
- R5: `sclk` idles low. `mosi` changes only while `sclk` is low and is sampled by the receiver on the rising edge. The first rising edge comes HALF cycles after `latch` falls, and each clock phase lasts HALF cycles, where HALF = max(1, CLK_HZ/(2*SCLK_HZ)). `sclk` is never high while `latch` is high.
- R6: After the last bit, `latch` stays low until the next sample instant.
- R7: `word_in` is registered on the accepted `adc_done`. Later changes to `word_in` do not alter the frame being sent.
- R8: `adc_done` outside the conversion wait is ignored: `sample_out` keeps its value, `sample_valid` stays low and no frame starts.
- R9: If a sample instant arrives while a conversion is awaited or a frame is in progress, `overrun` goes high and stays high until reset. `latch` still goes high, and the shift is abandoned with `sclk` and `mosi` low.
- R10: While `rst_n` is low: `latch` = 1, while `sclk`, `mosi`, `adc_start`, `sample_valid`, `overrun` and `sample_out` are all 0. Internal state leaves reset two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_done | input | 1 | ADC end-of-conversion, one-cycle pulse |
| adc_data | input | ADC_W | ADC result, valid with `adc_done` |
| word_in | input | 40 | Control byte and 32-bit tuning word for the next frame |
| sclk | output | 1 | Serial clock to the DDS, idle low |
| mosi | output | 1 | Serial data to the DDS, MSB first |
| latch | output | 1 | DDS select / frequency-update strobe; rising edge commits |
| adc_start | output | 1 | One-cycle conversion request on each sample instant |
| sample_out | output | ADC_W | Last captured ADC sample |
| sample_valid | output | 1 | One-cycle strobe when `sample_out` updates |
| overrun | output | 1 | Sticky: sample instant arrived before the frame ended |

## Verification
A wrong pacer count shifts every `adc_start` and every latch rise. It is visible at the first sample instant after reset and at every later one. A corrupt shift register or bit counter shows up as a wrong bit on `mosi` or a wrong number of `sclk` rises within one frame, at most about 240 cycles after the accepted `adc_done`. A wrong control state appears either as a `latch` edge in the wrong cycle or as `overrun` rising without cause. Because the bench model is compared on every clock, each of these faults is reported in the cycle it first reaches a port.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
  localparam int FRAME_W = 40;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } ld_state_t;
endpackage

// File: rtl/tick_pacer.sv
module tick_pacer #(
  parameter int PERIOD = 1250
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  generate
    if (PERIOD > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_ni)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int W    = 40,
  parameter int HALF = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         start,
  input  logic         abort,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         mosi,
  output logic         busy
);
  localparam int DW = $clog2(HALF + 1);
  localparam int BW = $clog2(W);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sclk_q, sclk_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    if (abort) begin
      busy_d = 1'b0;
      sclk_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      sh_d   = word;
    end else if (busy_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_d = 1'b0;
          end else begin
            bit_d = bit_q + BW'(1);
            sh_d  = {sh_q[W-2:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end

  assign sclk = sclk_q;
  assign busy = busy_q;
  assign mosi = busy_q & sh_q[W-1];

  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> (int'(bit_q) < W)); // R4
  AST_MOSI_SETTLED: assert property (@(posedge clk) disable iff (!rst_ni)
    (sclk_q && busy_q && $past(sclk_q)) |-> $stable(mosi)); // R5
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_loader_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SAMPLE_HZ = 40_000,
  parameter int SCLK_HZ   = 8_000_000,
  parameter int ADC_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adc_done,
  input  logic [ADC_W-1:0]   adc_data,
  input  logic [FRAME_W-1:0] word_in,
  output logic               sclk,
  output logic               mosi,
  output logic               latch,
  output logic               adc_start,
  output logic [ADC_W-1:0]   sample_out,
  output logic               sample_valid,
  output logic               overrun
);
  localparam int TICK_PERIOD = CLK_HZ / SAMPLE_HZ;
  localparam int HALF_RAW    = CLK_HZ / (2 * SCLK_HZ);
  localparam int HALF        = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic tick;
  logic shift_busy;
  logic start_shift;

  tick_pacer #(.PERIOD(TICK_PERIOD)) u_pacer (
    .clk    (clk),
    .rst_ni (rst_core_n),
    .tick   (tick)
  );

  ld_state_t        state_q, state_d;
  logic             latch_q, latch_d;
  logic             start_q, start_d;
  logic             valid_q, valid_d;
  logic             over_q, over_d;
  logic [ADC_W-1:0] smp_q, smp_d;

  assign start_shift = (state_q == ST_CONV) && adc_done && !tick;

  always_comb begin
    state_d = state_q;
    latch_d = latch_q;
    smp_d   = smp_q;
    start_d = tick;
    valid_d = start_shift;
    over_d  = over_q | (tick && (state_q != ST_IDLE));
    if (tick) begin
      state_d = ST_CONV;
      latch_d = 1'b1;
    end else if (start_shift) begin
      state_d = ST_SHIFT;
      latch_d = 1'b0;
      smp_d   = adc_data;
    end else if ((state_q == ST_SHIFT) && !shift_busy) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      latch_q <= 1'b1;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      over_q  <= 1'b0;
      smp_q   <= '0;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
      start_q <= start_d;
      valid_q <= valid_d;
      over_q  <= over_d;
      smp_q   <= smp_d;
    end
  end

  spi_frame_shifter #(.W(FRAME_W), .HALF(HALF)) u_shift (
    .clk    (clk),
    .rst_ni (rst_core_n),
    .start  (start_shift),
    .abort  (tick),
    .word   (word_in),
    .sclk   (sclk),
    .mosi   (mosi),
    .busy   (shift_busy)
  );

  assign latch        = latch_q;
  assign adc_start    = start_q;
  assign sample_valid = valid_q;
  assign sample_out   = smp_q;
  assign overrun      = over_q;

  AST_START_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    adc_start |-> latch); // R2
  AST_LATCH_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(latch) |-> adc_start); // R6
  AST_LATCH_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(latch) |-> ($past(adc_done) && sample_valid)); // R3
  AST_SCLK_UNDER_LATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    sclk |-> !latch); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    overrun |=> overrun); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    sample_valid |=> !sample_valid); // R3
endmodule

// File: tb/sim_dds_word_loader.sv
`timescale 1ns/1ps
module sim_dds_word_loader;
  localparam int CLK_HZ    = 50_000_000;
  localparam int SAMPLE_HZ = 40_000;
  localparam int SCLK_HZ   = 8_000_000;
  localparam int ADC_W     = 12;
  localparam int PER       = CLK_HZ / SAMPLE_HZ;
  localparam int HALF      = (CLK_HZ / (2 * SCLK_HZ) < 1) ? 1 : CLK_HZ / (2 * SCLK_HZ);

  logic             clk;
  logic             rst_n;
  logic             adc_done;
  logic [ADC_W-1:0] adc_data;
  logic [39:0]      word_in;
  logic             sclk, mosi, latch, adc_start, sample_valid, overrun;
  logic [ADC_W-1:0] sample_out;

  dds_word_loader #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .SCLK_HZ(SCLK_HZ),
                    .ADC_W(ADC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .adc_data(adc_data),
    .word_in(word_in), .sclk(sclk), .mosi(mosi), .latch(latch),
    .adc_start(adc_start), .sample_out(sample_out),
    .sample_valid(sample_valid), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 25)
        $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          s1 = 0, s2 = 0;
  int          m_cnt = 0;
  int          m_state = 0;   // 0 idle, 1 awaiting conversion, 2 shifting
  bit          m_latch = 1, m_start = 0, m_valid = 0, m_over = 0;
  bit          m_sclk = 0, m_busy = 0;
  int          m_div = 0, m_bit = 0;
  logic [39:0] m_word = '0;
  logic [ADC_W-1:0] m_sample = '0;

  always @(posedge clk) begin
    bit tk, busy_old, s2_old;
    cyc++;
    s2_old = s2;
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
    if (!rst_n || !s2_old) begin
      m_cnt = 0; m_state = 0; m_latch = 1; m_start = 0; m_valid = 0; m_over = 0;
      m_sclk = 0; m_busy = 0; m_div = 0; m_bit = 0; m_word = '0; m_sample = '0;
    end else begin
      busy_old = m_busy;
      tk = (m_cnt == PER - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      m_start = 0; m_valid = 0;
      if (m_busy) begin
        if (m_div == HALF - 1) begin
          m_div = 0;
          if (!m_sclk) m_sclk = 1;
          else begin
            m_sclk = 0;
            if (m_bit == 39) m_busy = 0;
            else begin m_bit++; m_word = m_word << 1; end
          end
        end else m_div++;
      end
      if (tk) begin
        if (m_state != 0) m_over = 1;
        m_latch = 1; m_start = 1; m_state = 1;
        m_busy = 0; m_sclk = 0; m_div = 0; m_bit = 0;
      end else if (m_state == 1 && adc_done) begin
        m_sample = adc_data; m_valid = 1; m_latch = 0; m_word = word_in;
        m_busy = 1; m_sclk = 0; m_div = 0; m_bit = 0; m_state = 2;
      end else if (m_state == 2 && !busy_old) begin
        m_state = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check(latch == m_latch, "R2", "latch vs model", latch, m_latch);
    check(adc_start == m_start, "R1", "adc_start vs model", adc_start, m_start);
    check(sclk == m_sclk, "R5", "sclk vs model", sclk, m_sclk);
    check(mosi == (m_busy & m_word[39]), "R4", "mosi vs model", mosi, m_busy & m_word[39]);
    check(sample_valid == m_valid, "R3", "sample_valid vs model", sample_valid, m_valid);
    check(sample_out == m_sample, "R8", "sample_out vs model", sample_out, m_sample);
    check(overrun == m_over, "R9", "overrun vs model", overrun, m_over);
  end

  // ---------------- frame receiver and timing checks ----------------
  bit          frame_chk_en = 1;
  bit          prev_sclk = 0, prev_latch = 1;
  bit          had_fall = 0;
  int          nbits = 0, fall_cyc = 0, last_start = -1;
  logic [39:0] rx = '0, exp_word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_start) begin
        if (last_start >= 0)
          check(cyc - last_start == PER, "R1", "sample period", cyc - last_start, PER);
        last_start = cyc;
      end
      if (prev_latch && !latch) begin
        had_fall = 1; nbits = 0; fall_cyc = cyc;
      end
      if (!prev_sclk && sclk) begin
        check(latch == 0, "R5", "latch low at sclk rise", latch, 0);
        if (nbits == 0)
          check(cyc - fall_cyc == HALF, "R5", "first edge delay", cyc - fall_cyc, HALF);
        rx = {rx[38:0], mosi};
        nbits++;
      end
      if (!prev_latch && latch) begin
        check(adc_start == 1, "R2", "latch rise with adc_start", adc_start, 1);
        if (frame_chk_en && had_fall) begin
          check(nbits == 40, "R4", "bits per frame", nbits, 40);
          check(rx == exp_word, "R7", "received word", rx, exp_word);
          check(cyc - fall_cyc > 80 * HALF, "R6", "latch low past frame end",
                cyc - fall_cyc, 80 * HALF);
        end
        had_fall = 0;
      end
    end
    prev_sclk = sclk;
    prev_latch = latch;
  end

  // ---------------- stimulus ----------------
  task automatic wait_start();
    do @(negedge clk); while (!adc_start);
  endtask

  task automatic do_frame(input int dly, input logic [ADC_W-1:0] d,
                          input logic [39:0] w, input bit scramble);
    wait_start();
    repeat (dly - 1) @(negedge clk);
    #1;
    adc_done = 1; adc_data = d; word_in = w; exp_word = w;
    @(negedge clk); #1;
    adc_done = 0;
    if (scramble) word_in = ~w;   // R7: change after capture
    adc_data = ~d;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0;
    @(negedge clk);
    check(latch == 1 && sclk == 0 && mosi == 0, "R10", "reset latch/sclk/mosi",
          {latch, sclk, mosi}, 3'b100);
    check(adc_start == 0 && sample_valid == 0 && overrun == 0 && sample_out == 0,
          "R10", "reset strobes/sample/overrun",
          {adc_start, sample_valid, overrun, sample_out}, 0);
    #1;
    rst_n = 1;
    last_start = -1; had_fall = 0;
  endtask

  initial begin
    rst_n = 0; adc_done = 0; adc_data = '0; word_in = '0;
    repeat (3) @(negedge clk);
    do_reset();

    do_frame(20,  12'h5A3, 40'h5A_1234_ABCD, 0);
    do_frame(5,   12'hFFF, 40'hFF_FFFF_FFFF, 1);
    do_frame(100, 12'h001, 40'h00_0000_0000, 1);
    do_frame(1,   12'h800, 40'h80_0000_0001, 0);
    do_frame(300, 12'h3C3, 40'hC3_A5A5_5A5A, 1);

    // R8: stray done while idle
    repeat (400) @(negedge clk);
    #1; adc_done = 1; adc_data = 12'hABC;
    @(negedge clk); #1; adc_done = 0;
    @(negedge clk);
    check(sample_out == 12'h3C3, "R8", "stray done ignored", sample_out, 12'h3C3);
    check(sample_valid == 0 && sclk == 0, "R8", "no strobe/no frame", {sample_valid, sclk}, 0);
    wait_start();
    check(overrun == 0, "R9", "no overrun in normal run", overrun, 0);

    // R9: late done makes the frame run into the next tick
    frame_chk_en = 0;
    do_frame(1100, 12'h2D2, 40'h3F_0F0F_F0F0, 0);
    wait_start();
    check(overrun == 1, "R9", "overrun set", overrun, 1);
    check(sclk == 0 && mosi == 0 && latch == 1, "R9", "shift abandoned",
          {sclk, mosi, latch}, 3'b001);
    // no done at all for one period: tick while awaiting conversion
    wait_start();
    check(overrun == 1, "R9", "overrun sticky", overrun, 1);

    do_reset();
    frame_chk_en = 1;
    do_frame(50, 12'h6B6, 40'h01_8765_4321, 1);
    wait_start();
    check(overrun == 0, "R10", "overrun cleared by reset", overrun, 0);
    repeat (5) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule